// File: doc/BRIEF.md
# Compare-Latch Conditional Branch Unit

This block resolves conditional branches for a small processor core in which comparison and branching are split across two instructions. A compare instruction hands over two 32-bit register values, and the unit keeps them exactly as given. It derives no flags from them. When a later branch instruction arrives, it carries a 4-bit condition code that picks one of ten relations: equality, inequality, and signed or unsigned ordering. That relation is tested on the held pair, first operand against second.

The unit also forms the branch destination. It takes the current program counter and a 10-bit offset that counts halfwords. The offset is sign-extended and doubled, then added to the address of the following instruction, which is PC + 2. The registered result is the next program counter plus a taken flag. Condition codes that name no relation raise an illegal-condition flag and never branch.

Both inputs are single-cycle strobes with no back-pressure. A compare or a branch can be presented on any cycle, both in the same cycle if needed, and each is accepted on the clock edge where its strobe is high. The results appear as a one-cycle pulse on the output valid.

Top module: `cmp_branch_unit`

## Requirements
- R1: After reset, both held operands are zero, and nxt_valid, taken, bad_cond and nxt_pc are all zero.
- R2: On a clock edge with cmp_valid high, cmp_lhs and cmp_rhs are stored unchanged as the first and second held operands. They then stay unchanged through any number of branches until the next compare strobe.
- R3: Condition codes 0 to 9 select these tests of the first held operand against the second: 0 equal, 1 not equal, 2 signed less, 3 signed greater, 4 unsigned less, 5 unsigned greater, 6 signed greater-or-equal, 7 signed less-or-equal, 8 unsigned greater-or-equal, 9 unsigned less-or-equal. taken is 1 exactly when the selected test holds.
- R4: Condition codes 10 to 15 give bad_cond = 1, taken = 0 and nxt_pc = br_pc + 2.
- R5: When taken, nxt_pc = br_pc + 2 + 2 × offset, where br_offset is a two's-complement halfword count. This gives a byte displacement from -1024 (offset 0x200) to +1022 (offset 0x1FF).
- R6: When a legal branch is not taken, nxt_pc = br_pc + 2 and bad_cond = 0.
- R7: nxt_valid, taken, bad_cond and nxt_pc are registered and are valid on the cycle after the br_valid edge. On a cycle after an edge without br_valid, nxt_valid, taken and bad_cond are 0.
- R8: When cmp_valid and br_valid are high on the same edge, the branch is evaluated on the operands held before that edge. The new pair is used from the next branch on.
- R9: All program-counter arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare strobe; captures the operand pair |
| cmp_lhs | input | 32 | First compare operand |
| cmp_rhs | input | 32 | Second compare operand |
| br_valid | input | 1 | Branch strobe |
| br_cond | input | 4 | Condition code |
| br_offset | input | 10 | Signed halfword offset |
| br_pc | input | 32 | Address of the branch instruction |
| nxt_valid | output | 1 | Pulse: branch result valid |
| nxt_pc | output | 32 | Next program counter |
| taken | output | 1 | Branch taken |
| bad_cond | output | 1 | Condition code names no relation |

## Verification
A compare strobe takes effect on the edge where it is sampled. The branch result is due exactly one cycle after the br_valid edge. The bench therefore drives every strobe just after a falling edge, lets one rising edge pass, and reads nxt_valid, taken, bad_cond and nxt_pc at the next falling edge, before any further stimulus.

All 16 condition codes are swept over every pair drawn from 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, and then over random pairs. The expected outcome comes from a signed/unsigned arithmetic model in the bench. Idle cycles are checked for silent outputs. A compare and a branch on the same edge are checked to confirm that the branch sees the older pair.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  typedef enum logic [3:0] {
    REL_EQ  = 4'd0,
    REL_NE  = 4'd1,
    REL_LT  = 4'd2,
    REL_GT  = 4'd3,
    REL_LTU = 4'd4,
    REL_GTU = 4'd5,
    REL_GE  = 4'd6,
    REL_LE  = 4'd7,
    REL_GEU = 4'd8,
    REL_LEU = 4'd9
  } rel_e;

  localparam int unsigned REL_COUNT = 10;

  typedef struct packed {
    logic eq;
    logic slt;
    logic ult;
  } cmp_flags_t;
endpackage

// File: rtl/operand_hold.sv
module operand_hold #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      a_q <= a_in;
      b_q <= b_in;
    end
  end
endmodule

// File: rtl/relation_eval.sv
module relation_eval
  import cbu_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned CW = 4
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [CW-1:0] cond,
  output logic          hit,
  output logic          legal
);
  cmp_flags_t fl;

  always_comb begin
    fl.eq  = (a == b);
    fl.ult = (a < b);
    fl.slt = ($signed(a) < $signed(b));
  end

  always_comb begin
    legal = (cond < CW'(REL_COUNT));
    hit   = 1'b0;
    if (legal) begin
      case (rel_e'(cond))
        REL_EQ:  hit = fl.eq;
        REL_NE:  hit = !fl.eq;
        REL_LT:  hit = fl.slt;
        REL_GT:  hit = !fl.slt && !fl.eq;
        REL_LTU: hit = fl.ult;
        REL_GTU: hit = !fl.ult && !fl.eq;
        REL_GE:  hit = !fl.slt;
        REL_LE:  hit = fl.slt || fl.eq;
        REL_GEU: hit = !fl.ult;
        REL_LEU: hit = fl.ult || fl.eq;
        default: hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/target_calc.sv
module target_calc #(
  parameter int unsigned PW         = 32,
  parameter int unsigned OW         = 10,
  parameter int unsigned INST_BYTES = 2
) (
  input  logic [PW-1:0] pc,
  input  logic [OW-1:0] off,
  output logic [PW-1:0] seq_pc,
  output logic [PW-1:0] jump_pc
);
  localparam int unsigned EXT_W = PW - OW;

  logic [PW-1:0] off_bytes;

  always_comb begin
    off_bytes = {{EXT_W{off[OW-1]}}, off} << 1;
    seq_pc    = pc + PW'(INST_BYTES);
    jump_pc   = seq_pc + off_bytes;
  end
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PC_W   = 32,
  parameter int unsigned OFF_W  = 10,
  parameter int unsigned COND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] cmp_lhs,
  input  logic [DATA_W-1:0] cmp_rhs,
  input  logic              br_valid,
  input  logic [COND_W-1:0] br_cond,
  input  logic [OFF_W-1:0]  br_offset,
  input  logic [PC_W-1:0]   br_pc,
  output logic              nxt_valid,
  output logic [PC_W-1:0]   nxt_pc,
  output logic              taken,
  output logic              bad_cond
);
  logic [DATA_W-1:0] hold_a, hold_b;
  logic              rel_hit, rel_legal;
  logic [PC_W-1:0]   seq_pc, jump_pc;

  operand_hold #(.W(DATA_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmp_valid),
    .a_in  (cmp_lhs),
    .b_in  (cmp_rhs),
    .a_q   (hold_a),
    .b_q   (hold_b)
  );

  relation_eval #(.W(DATA_W), .CW(COND_W)) u_rel (
    .a     (hold_a),
    .b     (hold_b),
    .cond  (br_cond),
    .hit   (rel_hit),
    .legal (rel_legal)
  );

  target_calc #(.PW(PC_W), .OW(OFF_W), .INST_BYTES(2)) u_tgt (
    .pc      (br_pc),
    .off     (br_offset),
    .seq_pc  (seq_pc),
    .jump_pc (jump_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_valid <= 1'b0;
      nxt_pc    <= '0;
      taken     <= 1'b0;
      bad_cond  <= 1'b0;
    end else begin
      nxt_valid <= br_valid;
      taken     <= br_valid && rel_hit;
      bad_cond  <= br_valid && !rel_legal;
      if (br_valid) begin
        nxt_pc <= rel_hit ? jump_pc : seq_pc;
      end
    end
  end
endmodule

// File: rtl/cbu_checker.sv
module cbu_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PC_W   = 32,
  parameter int unsigned OFF_W  = 10,
  parameter int unsigned COND_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_valid,
  input logic [DATA_W-1:0] cmp_lhs,
  input logic [DATA_W-1:0] cmp_rhs,
  input logic              br_valid,
  input logic [COND_W-1:0] br_cond,
  input logic [OFF_W-1:0]  br_offset,
  input logic [PC_W-1:0]   br_pc,
  input logic              nxt_valid,
  input logic [PC_W-1:0]   nxt_pc,
  input logic              taken,
  input logic              bad_cond,
  input logic [DATA_W-1:0] hold_a,
  input logic [DATA_W-1:0] hold_b
);
  // R2
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> (hold_a == $past(cmp_lhs)) && (hold_b == $past(cmp_rhs)));

  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(hold_a) && $stable(hold_b));

  // R7
  result_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> nxt_valid);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> !nxt_valid && !taken && !bad_cond);

  // R4
  illegal_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_cond > COND_W'(9)) |=>
      bad_cond && !taken && (nxt_pc == $past(br_pc) + PC_W'(2)));

  // R6
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> (taken || nxt_pc == $past(br_pc) + PC_W'(2)));

  // R3
  equal_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_cond == COND_W'(0)) |=> (taken == ($past(hold_a) == $past(hold_b))));

  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({taken, bad_cond}));
endmodule

bind cmp_branch_unit cbu_checker #(
  .DATA_W(DATA_W), .PC_W(PC_W), .OFF_W(OFF_W), .COND_W(COND_W)
) u_cbu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_valid (cmp_valid),
  .cmp_lhs   (cmp_lhs),
  .cmp_rhs   (cmp_rhs),
  .br_valid  (br_valid),
  .br_cond   (br_cond),
  .br_offset (br_offset),
  .br_pc     (br_pc),
  .nxt_valid (nxt_valid),
  .nxt_pc    (nxt_pc),
  .taken     (taken),
  .bad_cond  (bad_cond),
  .hold_a    (hold_a),
  .hold_b    (hold_b)
);

// File: tb/tb_cmp_branch_unit.sv
module tb_cmp_branch_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [31:0] cmp_lhs = '0, cmp_rhs = '0;
  logic        br_valid = 1'b0;
  logic [3:0]  br_cond = '0;
  logic [9:0]  br_offset = '0;
  logic [31:0] br_pc = '0;
  logic        nxt_valid, taken, bad_cond;
  logic [31:0] nxt_pc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_branch_unit dut (
    .clk(clk), .rst_n(rst_n),
    .cmp_valid(cmp_valid), .cmp_lhs(cmp_lhs), .cmp_rhs(cmp_rhs),
    .br_valid(br_valid), .br_cond(br_cond), .br_offset(br_offset), .br_pc(br_pc),
    .nxt_valid(nxt_valid), .nxt_pc(nxt_pc), .taken(taken), .bad_cond(bad_cond)
  );

  function automatic bit ref_rel(input int c, input logic [31:0] a, input logic [31:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = longint'({32'd0, a});
    longint ub = longint'({32'd0, b});
    case (c)
      0: return ua == ub;
      1: return ua != ub;
      2: return sa < sb;
      3: return sa > sb;
      4: return ua < ub;
      5: return ua > ub;
      6: return sa >= sb;
      7: return sa <= sb;
      8: return ua >= ub;
      9: return ua <= ub;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_compare(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_lhs = a; cmp_rhs = b;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  // Issue a branch and check the result one cycle later against held pair (ea, eb).
  task automatic do_branch(input int c, input logic [9:0] off, input logic [31:0] pc,
                           input logic [31:0] ea, input logic [31:0] eb);
    bit          exp_t, exp_bad;
    int          so;
    logic [31:0] exp_pc;
    @(negedge clk);
    br_valid = 1'b1; br_cond = 4'(c); br_offset = off; br_pc = pc;
    @(negedge clk);
    br_valid = 1'b0;
    exp_bad = (c > 9);
    exp_t   = ref_rel(c, ea, eb);
    so      = (off >= 10'd512) ? int'(off) - 1024 : int'(off);
    exp_pc  = exp_t ? pc + 32'd2 + 32'(so * 2) : pc + 32'd2;
    check(nxt_valid == 1'b1, "R7 nxt_valid after branch", 32'(nxt_valid), 32'd1);
    if (exp_bad) begin
      check(bad_cond == 1'b1 && taken == 1'b0, "R4 illegal code flags",
            {30'd0, bad_cond, taken}, 32'd2);
      check(nxt_pc == exp_pc, "R4 illegal code next pc", nxt_pc, exp_pc);
    end else begin
      check(taken == exp_t && bad_cond == 1'b0, "R3 relation outcome",
            {30'd0, bad_cond, taken}, {31'd0, exp_t});
      check(nxt_pc == exp_pc, exp_t ? "R5 taken target" : "R6 fall-through pc", nxt_pc, exp_pc);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] corners [5];
    logic [9:0]  offs [4];
    corners = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};
    offs    = '{10'h000, 10'h1FF, 10'h200, 10'h3FF};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of outputs
    check(nxt_valid == 0 && taken == 0 && bad_cond == 0, "R1 outputs after reset",
          {29'd0, nxt_valid, taken, bad_cond}, 32'd0);
    check(nxt_pc == 32'd0, "R1 nxt_pc after reset", nxt_pc, 32'd0);
    // R1: held pair is zero, so equal taken, signed less not taken
    do_branch(0, 10'h004, 32'h100, 32'd0, 32'd0);
    do_branch(2, 10'h004, 32'h100, 32'd0, 32'd0);

    // R7: idle cycle leaves outputs quiet
    @(negedge clk);
    check(nxt_valid == 0 && taken == 0 && bad_cond == 0, "R7 idle outputs",
          {29'd0, nxt_valid, taken, bad_cond}, 32'd0);

    // R3 R4 R5 R6: full condition sweep over corner pairs; R2 holds across 16 branches
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 5; j++) begin
        do_compare(corners[i], corners[j]);
        for (int c = 0; c < 16; c++)
          do_branch(c, offs[(c + i + j) % 4], 32'h0000_1000 + 32'(c * 64), corners[i], corners[j]);
      end
    end

    // R3: random operand pairs
    for (int k = 0; k < 150; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = (k % 5 == 0) ? ra : $urandom;
      do_compare(ra, rb);
      for (int c = 0; c < 16; c++)
        do_branch(c, 10'($urandom), $urandom & 32'hFFFF_FFFE, ra, rb);
    end

    // R9: wraparound of pc + 2 and of the taken target
    do_compare(32'd5, 32'd5);
    do_branch(1, 10'h010, 32'hFFFF_FFFE, 32'd5, 32'd5);
    do_branch(0, 10'h1FF, 32'hFFFF_FF00, 32'd5, 32'd5);
    do_branch(0, 10'h200, 32'h0000_0010, 32'd5, 32'd5);

    // R8: compare and branch on the same edge use the older pair
    do_compare(32'd1, 32'd2);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_lhs = 32'd9; cmp_rhs = 32'd9;
    br_valid = 1'b1; br_cond = 4'd0; br_offset = 10'h008; br_pc = 32'h200;
    @(negedge clk);
    cmp_valid = 1'b0; br_valid = 1'b0;
    check(taken == 1'b0, "R8 branch sees older pair", 32'(taken), 32'd0);
    check(nxt_pc == 32'h202, "R8 fall-through pc", nxt_pc, 32'h202);
    do_branch(0, 10'h008, 32'h200, 32'd9, 32'd9);

    // R2: hold survives idle cycles
    repeat (5) @(negedge clk);
    do_branch(7, 10'h3FF, 32'h40, 32'd9, 32'd9);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule